// File: doc/BRIEF.md
# Online-Trained Neural Sample Predictor

This block forecasts the next value of a scalar fixed-point time series. A small perceptron network makes the forecast from a short window of past samples. Every new sample first serves as the target for the forecast made from the previous window. The resulting error drives one backpropagation step on all weights, and then the window advances. The weights live in registers, so training runs continuously and needs no memory macros and no software.

The forward path has `N_IN` window inputs feeding `N_HID` hidden neurons. Each hidden neuron has a bias and a rectified-linear activation. A single linear output neuron with a bias follows them. The block accepts one sample per clock. It is deliberately not pipelined, because each weight update depends on the forecast that came just before it. A parameter selects a recurrent arrangement, in which the first network input is the block's own previous forecast instead of the newest sample. The forecast and the input share one signed fixed-point format, set by `TOTAL_W` and `FRAC_W`.

Top module: `tsp_mlp_predictor`

## Requirements
- R1: While `rst_n` is low, and right after it rises, `pred_valid` is 0, the sample history and the feedback register are zero, and the weights hold these values:
  - Hidden weight (neuron i, input j): (1+N_IN·i+j)·2^-6, negated when j is odd.
  - Hidden bias i: (2i−(N_HID−1))·2^-4.
  - Output weight i: (i+1)·2^-3.
  - Output bias: 2^-5.
- R2: A sample is accepted when `in_valid` is high at a rising clock edge. `pred_valid` is high for exactly the one cycle after an accepted sample, and only once at least N_IN samples have been accepted since reset. It is low in every other cycle.
- R3: `pred_sample` depends only on registered state, computed as follows:
  - Window input j is the j-th most recent accepted sample, with j=0 the newest.
  - Each hidden pre-activation is its bias plus the sum of weight·input. The products are summed exactly, then shifted right by FRAC_W with floor rounding, then saturated to TOTAL_W bits.
  - A hidden output equals its pre-activation when that is above zero, and zero otherwise.
  - The output is formed the same way from the hidden outputs, the output weights and the output bias, with no activation.
- R4: On an accepted sample that arrives while the history is already full, the error e is the saturated value of the sample minus the `pred_sample` present before the edge. Each output weight i grows by step(e·a_i), where a_i is the hidden output. The output bias grows by step(e).
- R5: The gradient of hidden neuron i is the saturated floor of e·v_i/2^FRAC_W, where v_i is the output weight before the update, when that neuron's pre-activation is above zero. Otherwise the gradient is 0. Each hidden weight grows by step(gradient·u_j) and each hidden bias by step(gradient).
- R6: A sample accepted while fewer than N_IN samples have been accepted since reset changes no weight.
- R7: The learning-rate code is LR=floor((8·2^FRAC_W+500)/1000), which is 0.008 rounded. step(p) first forms the product term q = sat(floor(p/2^FRAC_W)), then yields floor(LR·q/2^FRAC_W). Every updated weight is the saturated sum of the old weight and its step.
- R8: Pre-activations, the prediction, the error, the gradients and every weight saturate to the TOTAL_W two's-complement range instead of wrapping.
- R9: A cycle without an accepted sample changes no state: `pred_sample` holds its value and `pred_valid` is low.
- R10: With TOPO set to the recurrent value, window input 0 is a feedback register. On every accepted sample, including those before the history is full, this register takes the `pred_sample` value present before the edge. Inputs 1..N_IN−1 remain the history samples.
- R11: The formats 18.14, 16.12 and 14.10 (TOTAL_W.FRAC_W) are chosen by parameter alone. A parameter set outside the supported ranges stops elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Marks `in_sample` as a new series sample |
| in_sample | input | TOTAL_W | New sample, signed fixed point with FRAC_W fraction bits |
| pred_valid | output | 1 | One-cycle strobe marking a fresh forecast |
| pred_sample | output | TOTAL_W | Forecast of the next sample, same format as `in_sample` |

## Verification
The bench builds three copies side by side and drives them with one stimulus. The copies are 16.12 feed-forward, 18.14 recurrent and 14.10 feed-forward, so every format and both topologies are compared against a bit-exact model of the stated arithmetic. Because all three copies keep four integer bits, a single sample stream reaches the saturation limits of each format together. The recurrent copy exercises the feedback register through the fill phase and beyond. Long alternating full-scale runs drive the error and the pre-activations into clipping, and negative runs turn off hidden neurons so that gradient gating shows in the forecasts.

// File: rtl/tsp_pkg.sv
package tsp_pkg;

   // network arrangement: plain window or forecast fed back into input 0
   typedef enum logic {
      TOPO_FEEDFWD = 1'b0,
      TOPO_RECUR   = 1'b1
   } topo_e;

   // learning rate expressed as a ratio, quantised per fraction width
   localparam int LR_NUM = 8;
   localparam int LR_DEN = 1000;

   function automatic int lr_code(input int frac);
      return ((1 << frac) * LR_NUM + LR_DEN / 2) / LR_DEN;
   endfunction

endpackage

// File: rtl/tsp_window.sv
module tsp_window
   import tsp_pkg::*;
#(
   parameter int    W    = 16,
   parameter int    N_IN = 4,
   parameter topo_e TOPO = TOPO_FEEDFWD
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic signed [W-1:0] in_sample,
   input  logic signed [W-1:0] pred_now,
   output logic signed [W-1:0] u_o [N_IN],
   output logic                full_o,
   output logic                fire_o
);
   localparam int CW = $clog2(N_IN + 1);

   logic signed [W-1:0] hist_q [N_IN];
   logic signed [W-1:0] fb_q;
   logic [CW-1:0]       cnt_q;
   logic                fire_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < N_IN; k++) hist_q[k] <= '0;
         fb_q   <= '0;
         cnt_q  <= '0;
         fire_q <= 1'b0;
      end else begin
         fire_q <= in_valid && (cnt_q >= CW'(N_IN - 1));
         if (in_valid) begin
            hist_q[0] <= in_sample;
            for (int k = 1; k < N_IN; k++) hist_q[k] <= hist_q[k-1];
            fb_q <= pred_now;
            if (cnt_q != CW'(N_IN)) cnt_q <= cnt_q + CW'(1);
         end
      end
   end

   // input 0 source depends on the arrangement
   generate
      if (TOPO == TOPO_RECUR) begin : g_recur
         assign u_o[0] = fb_q;
      end else begin : g_plain
         assign u_o[0] = hist_q[0];
      end
      for (genvar k = 1; k < N_IN; k++) begin : g_tap
         assign u_o[k] = hist_q[k];
      end
   endgenerate

   assign full_o = (cnt_q == CW'(N_IN));
   assign fire_o = fire_q;

endmodule

// File: rtl/tsp_hidden_unit.sv
module tsp_hidden_unit #(
   parameter int W     = 16,
   parameter int F     = 12,
   parameter int N_IN  = 4,
   parameter int N_HID = 4,
   parameter int IDX   = 0,
   parameter int LR_Q  = 33
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                train_en,
   input  logic signed [W-1:0] u_i [N_IN],
   input  logic signed [W-1:0] err_i,
   input  logic signed [W-1:0] vout_i,
   output logic signed [W-1:0] act_o
);
   localparam int WIDE = 2 * W + 4;
   localparam logic signed [WIDE-1:0] HI  = WIDE'((64'sd1 <<< (W - 1)) - 64'sd1);
   localparam logic signed [WIDE-1:0] LO  = ~HI;
   localparam logic signed [WIDE-1:0] LRW = WIDE'(LR_Q);

   function automatic logic signed [W-1:0] clip(input logic signed [WIDE-1:0] v);
      if (v > HI) return HI[W-1:0];
      if (v < LO) return LO[W-1:0];
      return v[W-1:0];
   endfunction

   function automatic logic signed [W-1:0] w_init(input int j);
      logic signed [W-1:0] mag;
      mag = W'((1 + N_IN * IDX + j) << (F - 6));
      return (j % 2 == 1) ? -mag : mag;
   endfunction

   function automatic logic signed [W-1:0] b_init();
      return W'((2 * IDX - (N_HID - 1)) * (1 << (F - 4)));
   endfunction

   logic signed [W-1:0]    w_q  [N_IN];
   logic signed [W-1:0]    w_nx [N_IN];
   logic signed [W-1:0]    b_q, b_nx;
   logic signed [WIDE-1:0] acc;
   logic signed [W-1:0]    z, grad, term;
   logic                   live;

   always_comb begin
      acc = WIDE'(b_q) <<< F;
      for (int j = 0; j < N_IN; j++) acc = acc + WIDE'(w_q[j]) * WIDE'(u_i[j]);
      z     = clip(acc >>> F);
      live  = !z[W-1] && (z != '0);
      act_o = live ? z : '0;
      grad  = live ? clip((WIDE'(err_i) * WIDE'(vout_i)) >>> F) : '0;
      b_nx  = clip(WIDE'(b_q) + ((LRW * WIDE'(grad)) >>> F));
      term  = '0;
      for (int j = 0; j < N_IN; j++) begin
         term    = clip((WIDE'(grad) * WIDE'(u_i[j])) >>> F);
         w_nx[j] = clip(WIDE'(w_q[j]) + ((LRW * WIDE'(term)) >>> F));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         b_q <= b_init();
         for (int j = 0; j < N_IN; j++) w_q[j] <= w_init(j);
      end else if (train_en) begin
         b_q <= b_nx;
         for (int j = 0; j < N_IN; j++) w_q[j] <= w_nx[j];
      end
   end

endmodule

// File: rtl/tsp_out_unit.sv
module tsp_out_unit #(
   parameter int W     = 16,
   parameter int F     = 12,
   parameter int N_HID = 4,
   parameter int LR_Q  = 33
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                train_en,
   input  logic signed [W-1:0] act_i [N_HID],
   input  logic signed [W-1:0] target_i,
   output logic signed [W-1:0] pred_o,
   output logic signed [W-1:0] err_o,
   output logic signed [W-1:0] v_o [N_HID]
);
   localparam int WIDE = 2 * W + 4;
   localparam logic signed [WIDE-1:0] HI  = WIDE'((64'sd1 <<< (W - 1)) - 64'sd1);
   localparam logic signed [WIDE-1:0] LO  = ~HI;
   localparam logic signed [WIDE-1:0] LRW = WIDE'(LR_Q);

   function automatic logic signed [W-1:0] clip(input logic signed [WIDE-1:0] v);
      if (v > HI) return HI[W-1:0];
      if (v < LO) return LO[W-1:0];
      return v[W-1:0];
   endfunction

   logic signed [W-1:0]    v_q  [N_HID];
   logic signed [W-1:0]    v_nx [N_HID];
   logic signed [W-1:0]    bo_q, bo_nx, term;
   logic signed [WIDE-1:0] acc;

   always_comb begin
      acc = WIDE'(bo_q) <<< F;
      for (int i = 0; i < N_HID; i++) acc = acc + WIDE'(v_q[i]) * WIDE'(act_i[i]);
      pred_o = clip(acc >>> F);
      err_o  = clip(WIDE'(target_i) - WIDE'(pred_o));
      bo_nx  = clip(WIDE'(bo_q) + ((LRW * WIDE'(err_o)) >>> F));
      term   = '0;
      for (int i = 0; i < N_HID; i++) begin
         term    = clip((WIDE'(err_o) * WIDE'(act_i[i])) >>> F);
         v_nx[i] = clip(WIDE'(v_q[i]) + ((LRW * WIDE'(term)) >>> F));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bo_q <= W'(1 << (F - 5));
         for (int i = 0; i < N_HID; i++) v_q[i] <= W'((i + 1) << (F - 3));
      end else if (train_en) begin
         bo_q <= bo_nx;
         for (int i = 0; i < N_HID; i++) v_q[i] <= v_nx[i];
      end
   end

   assign v_o = v_q;

endmodule

// File: rtl/tsp_mlp_predictor.sv
module tsp_mlp_predictor #(
   parameter int             TOTAL_W = 16,
   parameter int             FRAC_W  = 12,
   parameter int             N_IN    = 4,
   parameter int             N_HID   = 4,
   parameter tsp_pkg::topo_e TOPO    = tsp_pkg::TOPO_FEEDFWD
)(
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      in_valid,
   input  logic signed [TOTAL_W-1:0] in_sample,
   output logic                      pred_valid,
   output logic signed [TOTAL_W-1:0] pred_sample
);
   localparam int LR_Q = tsp_pkg::lr_code(FRAC_W);

   // parameter legality, checked while elaborating (R11)
   generate
      if (TOTAL_W < 8 || TOTAL_W > 24) begin : g_bad_width
         $error("tsp_mlp_predictor: TOTAL_W out of range");
      end
      if (FRAC_W < 6 || FRAC_W > TOTAL_W - 2) begin : g_bad_frac
         $error("tsp_mlp_predictor: FRAC_W out of range");
      end
      if (N_IN < 2 || N_IN > 8 || N_HID < 1 || N_HID > 8) begin : g_bad_shape
         $error("tsp_mlp_predictor: network shape out of range");
      end
   endgenerate

   logic signed [TOTAL_W-1:0] u   [N_IN];
   logic signed [TOTAL_W-1:0] act [N_HID];
   logic signed [TOTAL_W-1:0] vw  [N_HID];
   logic signed [TOTAL_W-1:0] err;
   logic signed [TOTAL_W-1:0] pred;
   logic                      full;
   logic                      fire;
   logic                      train_en;

   assign train_en = in_valid && full;

   tsp_window #(.W(TOTAL_W), .N_IN(N_IN), .TOPO(TOPO)) win_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_sample (in_sample),
      .pred_now  (pred),
      .u_o       (u),
      .full_o    (full),
      .fire_o    (fire)
   );

   generate
      for (genvar i = 0; i < N_HID; i++) begin : g_hid
         tsp_hidden_unit #(
            .W(TOTAL_W), .F(FRAC_W), .N_IN(N_IN), .N_HID(N_HID), .IDX(i), .LR_Q(LR_Q)
         ) hid_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .train_en (train_en),
            .u_i      (u),
            .err_i    (err),
            .vout_i   (vw[i]),
            .act_o    (act[i])
         );
      end
   endgenerate

   tsp_out_unit #(.W(TOTAL_W), .F(FRAC_W), .N_HID(N_HID), .LR_Q(LR_Q)) out_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .train_en (train_en),
      .act_i    (act),
      .target_i (in_sample),
      .pred_o   (pred),
      .err_o    (err),
      .v_o      (vw)
   );

   assign pred_valid  = fire;
   assign pred_sample = pred;

endmodule

// File: rtl/tsp_mlp_predictor_chk.sv
module tsp_mlp_predictor_chk #(
   parameter int TOTAL_W = 16,
   parameter int N_IN    = 4
)(
   input logic                      clk,
   input logic                      rst_n,
   input logic                      in_valid,
   input logic signed [TOTAL_W-1:0] in_sample,
   input logic                      pred_valid,
   input logic signed [TOTAL_W-1:0] pred_sample
);
   localparam int CW = $clog2(N_IN + 1);

   // independent count of accepted samples, saturating at N_IN
   logic [CW-1:0] seen_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen_q <= '0;
      else if (in_valid && seen_q != CW'(N_IN)) seen_q <= seen_q + CW'(1);
   end

   p_fill_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && seen_q < CW'(N_IN - 1)) |=> !pred_valid);

   p_fill_fire_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && seen_q >= CW'(N_IN - 1)) |=> pred_valid);

   p_valid_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
      pred_valid |-> $past(in_valid));

   p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(pred_sample));

   p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !pred_valid);

   p_sample_known_r3: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> !$isunknown(in_sample));

endmodule

bind tsp_mlp_predictor tsp_mlp_predictor_chk #(.TOTAL_W(TOTAL_W), .N_IN(N_IN)) chk_i (.*);

// File: tb/tsp_mlp_predictor_tb_top.sv
module tsp_mlp_predictor_tb_top;
   timeunit 1ns;
   timeprecision 1ps;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic va = 1'b0;
   logic signed [15:0] sa = '0;
   logic signed [17:0] sb = '0;
   logic signed [13:0] sc = '0;
   logic pva, pvb, pvc;
   logic signed [15:0] pa;
   logic signed [17:0] pb;
   logic signed [13:0] pc;

   always #2.5 clk = ~clk;   // 200 MHz

   tsp_mlp_predictor #(.TOTAL_W(16), .FRAC_W(12)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(va), .in_sample(sa),
      .pred_valid(pva), .pred_sample(pa));
   tsp_mlp_predictor #(.TOTAL_W(18), .FRAC_W(14), .TOPO(tsp_pkg::TOPO_RECUR)) dut_r (
      .clk(clk), .rst_n(rst_n), .in_valid(va), .in_sample(sb),
      .pred_valid(pvb), .pred_sample(pb));
   tsp_mlp_predictor #(.TOTAL_W(14), .FRAC_W(10)) dut_n (
      .clk(clk), .rst_n(rst_n), .in_valid(va), .in_sample(sc),
      .pred_valid(pvc), .pred_sample(pc));

   int n_checks = 0;
   int n_errors = 0;

   // ---------------- reference model, one slot per copy ----------------
   int WK [3] = '{16, 18, 14};
   int FK [3] = '{12, 14, 10};
   bit RK [3] = '{1'b0, 1'b1, 1'b0};
   longint mw [3][4][4];
   longint mb [3][4];
   longint mv [3][4];
   longint mbo [3];
   longint hist [3][4];
   longint fb [3];
   int cnt [3];
   bit exp_v [3];

   function automatic longint clipv(input longint v, input int w);
      longint mx;
      mx = (longint'(1) <<< (w - 1)) - 1;
      if (v > mx) return mx;
      if (v < -mx - 1) return -mx - 1;
      return v;
   endfunction

   function automatic longint lr_of(input int f);
      return ((longint'(1) <<< f) * 8 + 500) / 1000;
   endfunction

   function automatic longint m_in(input int k, input int j);
      return (j == 0 && RK[k]) ? fb[k] : hist[k][j];
   endfunction

   task automatic m_reset();
      for (int k = 0; k < 3; k++) begin
         for (int i = 0; i < 4; i++) begin
            for (int j = 0; j < 4; j++)
               mw[k][i][j] = ((j % 2 == 1) ? -1 : 1) * longint'(1 + 4 * i + j) * (longint'(1) <<< (FK[k] - 6));
            mb[k][i] = longint'(2 * i - 3) * (longint'(1) <<< (FK[k] - 4));
            mv[k][i] = longint'(i + 1) * (longint'(1) <<< (FK[k] - 3));
            hist[k][i] = 0;
         end
         mbo[k] = longint'(1) <<< (FK[k] - 5);
         fb[k] = 0;
         cnt[k] = 0;
         exp_v[k] = 1'b0;
      end
   endtask

   task automatic m_fwd(input int k, output longint z [4], output longint y);
      longint acc;
      int f, w;
      f = FK[k]; w = WK[k];
      for (int i = 0; i < 4; i++) begin
         acc = mb[k][i] <<< f;
         for (int j = 0; j < 4; j++) acc += mw[k][i][j] * m_in(k, j);
         z[i] = clipv(acc >>> f, w);
      end
      acc = mbo[k] <<< f;
      for (int i = 0; i < 4; i++) acc += mv[k][i] * ((z[i] > 0) ? z[i] : 0);
      y = clipv(acc >>> f, w);
   endtask

   task automatic m_accept(input int k, input int s);
      longint z [4];
      longint u [4];
      longint y, x, e, g, p, a, lr;
      int f, w;
      f = FK[k]; w = WK[k]; lr = lr_of(f);
      m_fwd(k, z, y);
      for (int j = 0; j < 4; j++) u[j] = m_in(k, j);
      x = longint'(s) <<< (f - 10);
      if (cnt[k] == 4) begin
         e = clipv(x - y, w);
         for (int i = 0; i < 4; i++) begin
            g = (z[i] > 0) ? clipv((e * mv[k][i]) >>> f, w) : 0;
            for (int j = 0; j < 4; j++) begin
               p = clipv((g * u[j]) >>> f, w);
               mw[k][i][j] = clipv(mw[k][i][j] + ((lr * p) >>> f), w);
            end
            mb[k][i] = clipv(mb[k][i] + ((lr * g) >>> f), w);
         end
         for (int i = 0; i < 4; i++) begin
            a = (z[i] > 0) ? z[i] : 0;
            p = clipv((e * a) >>> f, w);
            mv[k][i] = clipv(mv[k][i] + ((lr * p) >>> f), w);
         end
         mbo[k] = clipv(mbo[k] + ((lr * e) >>> f), w);
      end
      fb[k] = y;
      for (int j = 3; j > 0; j--) hist[k][j] = hist[k][j-1];
      hist[k][0] = x;
      if (cnt[k] < 4) cnt[k]++;
   endtask

   // ---------------- checking helpers ----------------
   function automatic longint dut_pred(input int k);
      case (k)
         0: return longint'(pa);
         1: return longint'(pb);
         default: return longint'(pc);
      endcase
   endfunction

   function automatic bit dut_valid(input int k);
      case (k)
         0: return pva;
         1: return pvb;
         default: return pvc;
      endcase
   endfunction

   task automatic chk(input string tag, input longint act, input longint exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   task automatic check_all(input string tag);
      longint z [4];
      longint y;
      for (int k = 0; k < 3; k++) begin
         m_fwd(k, z, y);
         chk($sformatf("%s copy%0d valid", tag, k), longint'(dut_valid(k)), longint'(exp_v[k]));
         chk($sformatf("%s copy%0d pred", tag, k), dut_pred(k), y);
      end
   endtask

   // one clock: drive at the falling edge, check at the next falling edge
   task automatic step(input bit v, input int s, input string tag);
      va = v;
      sa = 16'(s <<< 2);
      sb = 18'(s <<< 4);
      sc = 14'(s);
      for (int k = 0; k < 3; k++) begin
         if (v) m_accept(k, s);
         exp_v[k] = v && (cnt[k] == 4);
      end
      @(posedge clk);
      @(negedge clk);
      check_all(tag);
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      @(negedge clk);
      rst_n = 1'b0;
      va = 1'b0;
      m_reset();
      repeat (3) @(negedge clk);
      check_all("R1 in-reset");
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R1 post-reset");
   endtask

   task automatic t_fill();
      step(1'b1, 512, "R2/R6 fill1");
      step(1'b1, 700, "R2/R6 fill2");
      step(1'b0, 0, "R2 gap");
      step(1'b1, 900, "R2/R6 fill3");
      step(1'b1, 1100, "R2/R3/R6 fill4");
   endtask

   task automatic t_track();
      for (int n = 0; n < 24; n++)
         step(1'b1, ((n * 611) % 3000) - 1000, "R3/R4/R7/R11 track");
   endtask

   task automatic t_negative();
      for (int n = 0; n < 12; n++)
         step(1'b1, -3000 - 150 * n, "R5 gate");
      for (int n = 0; n < 6; n++)
         step(1'b1, 2500 - 900 * n, "R4/R5 swing");
   endtask

   task automatic t_idle();
      for (int n = 0; n < 5; n++) step(1'b0, 4000 + n, "R9 idle");
      step(1'b1, 300, "R9 resume");
      step(1'b0, -7000, "R9 idle2");
   endtask

   task automatic t_saturate();
      for (int n = 0; n < 60; n++)
         step(1'b1, (n % 2 == 0) ? 8191 : -8192, "R8 clip");
      for (int n = 0; n < 8; n++)
         step(1'b1, 8191, "R8 rail");
   endtask

   task automatic t_recur();
      t_reset();
      for (int n = 0; n < 10; n++)
         step(1'b1, 200 * n - 700, "R10/R6 recur");
   endtask

   bit done = 1'b0;

   initial begin
      t_reset();
      t_fill();
      t_track();
      t_negative();
      t_idle();
      t_saturate();
      t_recur();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog act=running exp=finished");
         $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
         $finish;
      end
   end

endmodule